// File: doc/BRIEF.md
# Serial EEPROM Slave Model

This block models a byte-wide serial EEPROM that answers as a slave on a four-wire SPI link. Everything runs on one system clock. The select, serial clock, pause and serial-data inputs pass through a multi-flop synchronizer. The rising edges of the serial clock are then found inside the block. Each transaction starts with an 8-bit command and, for array access, a 16-bit address. Data bytes follow the address.

A small status register holds a write-enable latch and a two-bit protect field. Together they decide whether a data byte reaches the internal byte RAM. The RAM depth is a parameter, and both the incoming address and the protect regions scale to it. A write burst steps through a 128-byte page and wraps inside that page. A read burst steps through the whole array and wraps at its end. A system model drops the block onto its SPI pins to stand in for a real storage part.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset `ser_out` is 1 and the status register reads 0x00. The block waits for a command.
- R2: With `sel_n` low and `pause_n` high, the block samples `ser_in` at each rising edge of `ser_clk`, most significant bit first. It takes 8 bits of command, then 16 bits of address, then 8 bits per data byte.
- R3: The status byte carries the write-enable latch at bit 1 and the protect field at bits 3:2. All other bits read 0. Command 0x06 sets the latch and command 0x04 clears it. Command 0x01 followed by a byte loads only bits 3:2 of that byte and leaves the latch unchanged.
- R4: Command 0x02 is followed by an address and data bytes. A data byte is stored only while the write-enable latch is 1. A store does not clear the latch.
- R5: The protect field limits where stores may land, on the array of 2^MEM_AW bytes. A value of 0 protects nothing. A value of 1 protects the top quarter (the two address MSBs are 11). A value of 2 protects the top half (the address MSB is 1). A value of 3 protects the whole array.
- R6: After each data byte of a write, the low 7 address bits increment and wrap from 127 to 0. The upper address bits stay fixed.
- R7: Command 0x03 is followed by an address and then returns array bytes on `ser_out`, MSB first. Each bit is driven after a rising edge of `ser_clk`. Successive bytes come from address+1, and the address wraps from the last array byte to 0.
- R8: Command 0x05 returns the status byte and then repeats it for as long as the clock keeps running.
- R9: Raising `sel_n` ends the transaction at any bit. A partial command or data byte has no effect, `ser_out` returns to 1, and the next transaction starts with a fresh command.
- R10: While `pause_n` is low, the block ignores `ser_clk`, `ser_in` and `sel_n`. Its bit position, address and output stay unchanged.
- R11: Any other command value parks the block. Further clocks have no effect and `ser_out` stays 1 until `sel_n` rises.
- R12: Only the low MEM_AW bits of the 16-bit address are used. Upper address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low slave select |
| ser_clk | input | 1 | Serial clock from the master |
| pause_n | input | 1 | Active-low pause; freezes the block |
| ser_in | input | 1 | Serial data from the master |
| ser_out | output | 1 | Serial data to the master |

## Verification
The hardest situations to reach from the pins are the ones where the transfer stops in the middle. The first is a select release partway through a command or a data byte. The second is a pause held across several serial-clock pulses in the middle of a read. The bench drives the serial pins bit by bit, so it can cut a byte after any bit count. It then shows that nothing leaked through. For the aborted write it reads the target byte back. For the aborted command it confirms that the next full command still aligns. For the paused read it checks that the byte after the pause is still the addressed one. Reaching the protect boundaries takes several steps: known values are first stored at the edge addresses, the protect field is then loaded through a status write, and the bench tries to overwrite on each side of the boundary.

// File: rtl/eep_pkg.sv
package eep_pkg;

   localparam int FRAME_ADDR_W = 16;
   localparam int BYTE_W       = 8;

   typedef enum logic [2:0] {
      PH_CMD  = 3'd0,
      PH_ADDR = 3'd1,
      PH_WDAT = 3'd2,
      PH_RDAT = 3'd3,
      PH_PARK = 3'd4
   } phase_e;

   localparam logic [7:0] CMD_SET_STATUS = 8'h01;
   localparam logic [7:0] CMD_STORE      = 8'h02;
   localparam logic [7:0] CMD_FETCH      = 8'h03;
   localparam logic [7:0] CMD_LOCK       = 8'h04;
   localparam logic [7:0] CMD_GET_STATUS = 8'h05;
   localparam logic [7:0] CMD_UNLOCK     = 8'h06;

   function automatic logic [7:0] status_byte(input logic wen, input logic [1:0] guard);
      return {4'b0000, guard, wen, 1'b0};
   endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
   parameter int            W       = 4,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eep_sync: STAGES must be at least 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < W; gi++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= {STAGES{RST_VAL[gi]}};
            end else begin
               chain <= {chain[STAGES-2:0], d[gi]};
            end
         end
         assign q[gi] = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/eep_guard.sv
module eep_guard #(
   parameter int AW = 10
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    guard,
   output logic          blocked
);

   logic [1:0] top2;
   assign top2 = addr[AW-1:AW-2];

   always_comb begin
      unique case (guard)
         2'd0:    blocked = 1'b0;
         2'd1:    blocked = (top2 == 2'b11);
         2'd2:    blocked = top2[1];
         default: blocked = 1'b1;
      endcase
   end

endmodule

// File: rtl/eep_byte_ram.sv
module eep_byte_ram #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);

   localparam int DEPTH = 1 << AW;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[addr] <= wdata;
      end
   end

   assign rdata = cells[addr];

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
   parameter int MEM_AW      = 10,
   parameter int PAGE_AW     = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n,
   input  logic ser_clk,
   input  logic pause_n,
   input  logic ser_in,
   output logic ser_out
);
   import eep_pkg::*;

   localparam int CNT_W    = $clog2(FRAME_ADDR_W);
   localparam int BYTE_END = BYTE_W - 1;
   localparam int ADDR_END = FRAME_ADDR_W - 1;

   generate
      if (MEM_AW <= PAGE_AW || MEM_AW > FRAME_ADDR_W) begin : g_bad_aw
         $error("serial_eeprom_slave: MEM_AW must exceed PAGE_AW and fit the frame address");
      end
      if (PAGE_AW < 1) begin : g_bad_page
         $error("serial_eeprom_slave: PAGE_AW must be positive");
      end
   endgenerate

   // input synchronizer: {select, pause, clock, data}
   logic [3:0] pins_raw, pins_s;
   assign pins_raw = {sel_n, pause_n, ser_clk, ser_in};

   eep_sync #(
      .W      (4),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b1100)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw),
      .q    (pins_s)
   );

   logic sel_q, pause_q, sclk_q, sdi_q;
   assign sel_q   = pins_s[3];
   assign pause_q = pins_s[2];
   assign sclk_q  = pins_s[1];
   assign sdi_q   = pins_s[0];

   // serial clock edge detection; history always tracks so pause leaves no stale edge
   logic sclk_d;
   logic sclk_rise;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
      end else begin
         sclk_d <= sclk_q;
      end
   end
   assign sclk_rise = sclk_q & ~sclk_d;

   // state
   phase_e            phase;
   logic [CNT_W-1:0]  bit_cnt;
   logic [7:0]        cmd;
   logic [6:0]        dshift;
   logic [MEM_AW-1:0] addr;
   logic              wen;
   logic [1:0]        guard;
   logic              sdo_r;

   logic [7:0]        cmd_nx;
   logic [7:0]        dat_nx;
   logic [MEM_AW-1:0] addr_shift;
   logic [MEM_AW-1:0] addr_page_nx;
   logic [MEM_AW-1:0] addr_lin_nx;
   logic              byte_done;
   logic              addr_done;
   logic [7:0]        rd_byte;
   logic [7:0]        out_byte;
   logic              blocked;
   logic              mem_we;

   assign cmd_nx       = {cmd[6:0], sdi_q};
   assign dat_nx       = {dshift, sdi_q};
   assign addr_shift   = {addr[MEM_AW-2:0], sdi_q};
   assign addr_page_nx = {addr[MEM_AW-1:PAGE_AW], addr[PAGE_AW-1:0] + 1'b1};
   assign addr_lin_nx  = addr + 1'b1;
   assign byte_done    = (bit_cnt == CNT_W'(BYTE_END));
   assign addr_done    = (bit_cnt == CNT_W'(ADDR_END));
   assign out_byte     = (cmd == CMD_FETCH) ? rd_byte : status_byte(wen, guard);

   eep_guard #(
      .AW(MEM_AW)
   ) u_guard (
      .addr   (addr),
      .guard  (guard),
      .blocked(blocked)
   );

   assign mem_we = pause_q && !sel_q && sclk_rise && (phase == PH_WDAT) &&
                   byte_done && !cmd[0] && wen && !blocked;

   eep_byte_ram #(
      .AW(MEM_AW)
   ) u_ram (
      .clk  (clk),
      .we   (mem_we),
      .addr (addr),
      .wdata(dat_nx),
      .rdata(rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_CMD;
         bit_cnt <= '0;
         cmd     <= '0;
         dshift  <= '0;
         addr    <= '0;
         wen     <= 1'b0;
         guard   <= 2'b00;
         sdo_r   <= 1'b1;
      end else if (pause_q) begin
         if (sel_q) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
            cmd     <= '0;
            sdo_r   <= 1'b1;
         end else if (sclk_rise) begin
            unique case (phase)
               PH_CMD: begin
                  cmd     <= cmd_nx;
                  bit_cnt <= bit_cnt + 1'b1;
                  if (byte_done) begin
                     bit_cnt <= '0;
                     case (cmd_nx)
                        CMD_SET_STATUS: phase <= PH_WDAT;
                        CMD_STORE:      phase <= PH_ADDR;
                        CMD_FETCH:      phase <= PH_ADDR;
                        CMD_LOCK: begin
                           wen   <= 1'b0;
                           phase <= PH_PARK;
                        end
                        CMD_GET_STATUS: phase <= PH_RDAT;
                        CMD_UNLOCK: begin
                           wen   <= 1'b1;
                           phase <= PH_PARK;
                        end
                        default:        phase <= PH_PARK;
                     endcase
                  end
               end
               PH_ADDR: begin
                  addr    <= addr_shift;
                  bit_cnt <= bit_cnt + 1'b1;
                  if (addr_done) begin
                     bit_cnt <= '0;
                     phase   <= cmd[0] ? PH_RDAT : PH_WDAT;
                  end
               end
               PH_WDAT: begin
                  dshift  <= dat_nx[6:0];
                  bit_cnt <= bit_cnt + 1'b1;
                  if (byte_done) begin
                     bit_cnt <= '0;
                     if (cmd[0]) begin
                        guard <= dat_nx[3:2];
                        phase <= PH_PARK;
                     end else begin
                        addr  <= addr_page_nx;
                     end
                  end
               end
               PH_RDAT: begin
                  sdo_r   <= out_byte[3'(BYTE_END) - bit_cnt[2:0]];
                  bit_cnt <= bit_cnt + 1'b1;
                  if (byte_done) begin
                     bit_cnt <= '0;
                     if (cmd == CMD_FETCH) begin
                        addr <= addr_lin_nx;
                     end
                  end
               end
               default: begin
                  phase <= PH_PARK;
               end
            endcase
         end
      end
   end

   assign ser_out = sdo_r;

endmodule

// File: rtl/eep_checks.sv
module eep_checks #(
   parameter int MEM_AW  = 10,
   parameter int PAGE_AW = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_q,
   input logic              pause_q,
   input logic              ser_out,
   input eep_pkg::phase_e   phase,
   input logic [3:0]        bit_cnt,
   input logic [MEM_AW-1:0] addr,
   input logic              mem_we,
   input logic              wen,
   input logic [1:0]        guard
);
   import eep_pkg::*;

   assert_release_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_q && sel_q) |=> (ser_out && phase == PH_CMD && bit_cnt == 4'd0));

   assert_pause_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pause_q |=> ($stable(phase) && $stable(bit_cnt) && $stable(addr) && $stable(ser_out)));

   assert_store_needs_wen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wen);

   assert_guard_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (guard != 2'd3));

   assert_guard_quarter_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && guard == 2'd1) |-> (addr[MEM_AW-1:MEM_AW-2] != 2'b11));

   assert_guard_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && guard == 2'd2) |-> !addr[MEM_AW-1]);

   assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (addr[MEM_AW-1:PAGE_AW] == $past(addr[MEM_AW-1:PAGE_AW])));

   assert_cmd_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CMD) |-> (bit_cnt < 4'd8));

   assert_park_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PARK && !sel_q) |=> (phase == PH_PARK && $stable(ser_out)));

endmodule

bind serial_eeprom_slave eep_checks #(
   .MEM_AW (MEM_AW),
   .PAGE_AW(PAGE_AW)
) u_checks (
   .clk    (clk),
   .rst_n  (rst_n),
   .sel_q  (sel_q),
   .pause_q(pause_q),
   .ser_out(ser_out),
   .phase  (phase),
   .bit_cnt(bit_cnt),
   .addr   (addr),
   .mem_we (mem_we),
   .wen    (wen),
   .guard  (guard)
);

// File: tb/tb_serial_eeprom_slave.sv
module tb_serial_eeprom_slave;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;
   localparam int MEM_AW     = 10;
   localparam int DEPTH      = 1 << MEM_AW;

   logic clk = 1'b0;
   logic rst_n, sel_n, ser_clk, pause_n, ser_in;
   logic ser_out;

   int n_chk = 0;
   int n_err = 0;

   logic [7:0] mdl   [DEPTH];
   bit         known [DEPTH];
   logic       m_wen;
   logic [1:0] m_guard;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_eeprom_slave #(.MEM_AW(MEM_AW)) dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_n  (sel_n),
      .ser_clk(ser_clk),
      .pause_n(pause_n),
      .ser_in (ser_in),
      .ser_out(ser_out)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got=%h expected=%h", req, got, exp);
      end
   endtask

   function automatic bit is_blocked(input int a, input logic [1:0] g);
      logic [1:0] top2;
      top2 = 2'((a >> (MEM_AW - 2)) & 3);
      case (g)
         2'd0:    return 1'b0;
         2'd1:    return top2 == 2'b11;
         2'd2:    return top2[1];
         default: return 1'b1;
      endcase
   endfunction

   function automatic int page_step(input int a);
      return (a & ~127) | ((a + 1) & 127);
   endfunction

   function automatic logic [7:0] m_status();
      return {4'b0000, m_guard, m_wen, 1'b0};
   endfunction

   task automatic bits(input logic [15:0] v, input int n, output logic [15:0] r);
      r = '0;
      for (int i = n - 1; i >= 0; i--) begin
         ser_in = v[i];
         tick(HALF);
         ser_clk = 1'b1;
         tick(HALF);
         r[i] = ser_out;
         ser_clk = 1'b0;
      end
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      logic [15:0] r;
      bits({8'h00, tx}, 8, r);
      rx = r[7:0];
   endtask

   task automatic open_t();
      sel_n = 1'b0;
      tick(4);
   endtask

   task automatic close_t();
      ser_clk = 1'b0;
      sel_n = 1'b1;
      tick(6);
   endtask

   task automatic simple_cmd(input logic [7:0] c);
      logic [7:0] rx;
      open_t();
      xbyte(c, rx);
      close_t();
      if (c == 8'h06) m_wen = 1'b1;
      if (c == 8'h04) m_wen = 1'b0;
   endtask

   task automatic set_status(input logic [7:0] v);
      logic [7:0] rx;
      open_t();
      xbyte(8'h01, rx);
      xbyte(v, rx);
      close_t();
      m_guard = v[3:2];
   endtask

   task automatic get_status(input string req);
      logic [7:0] rx;
      open_t();
      xbyte(8'h05, rx);
      xbyte(8'h00, rx);
      check8(req, rx, m_status());
      close_t();
   endtask

   task automatic put_mem(input logic [15:0] a16, input int n);
      logic [7:0]  rx;
      logic [15:0] r;
      int          a;
      logic [7:0]  d;
      a = int'(a16) & (DEPTH - 1);
      open_t();
      xbyte(8'h02, rx);
      bits(a16, 16, r);
      for (int k = 0; k < n; k++) begin
         d = 8'($urandom);
         xbyte(d, rx);
         if (m_wen && !is_blocked(a, m_guard)) begin
            mdl[a]   = d;
            known[a] = 1'b1;
         end
         a = page_step(a);
      end
      close_t();
   endtask

   task automatic get_mem(input logic [15:0] a16, input int n, input string req);
      logic [7:0]  rx;
      logic [15:0] r;
      int          a;
      a = int'(a16) & (DEPTH - 1);
      open_t();
      xbyte(8'h03, rx);
      bits(a16, 16, r);
      for (int k = 0; k < n; k++) begin
         xbyte(8'h00, rx);
         if (known[a]) check8(req, rx, mdl[a]);
         a = (a + 1) % DEPTH;
      end
      close_t();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      logic [7:0]  rx;
      logic [15:0] r;
      void'($urandom(32'h00C0FFEE));
      m_wen = 1'b0;
      m_guard = 2'b00;
      rst_n = 1'b0; sel_n = 1'b1; ser_clk = 1'b0; pause_n = 1'b1; ser_in = 1'b0;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R1: reset state
      check8("R1 idle output", {7'd0, ser_out}, 8'h01);
      get_status("R1 status after reset");

      // R3/R4: latch control and gated stores
      simple_cmd(8'h06);
      get_status("R3 latch set");
      put_mem(16'h0010, 2);
      get_mem(16'h0010, 2, "R2 R4 stored bytes");
      get_status("R4 latch kept after store");
      simple_cmd(8'h04);
      get_status("R3 latch cleared");
      put_mem(16'h0010, 1);
      get_mem(16'h0010, 1, "R4 store without latch");

      // R5: protect boundaries
      simple_cmd(8'h06);
      put_mem(16'h02FF, 1); put_mem(16'h0300, 1); put_mem(16'h01FF, 1);
      put_mem(16'h0200, 1); put_mem(16'h0000, 1); put_mem(16'h03FF, 1);
      set_status(8'hFF);
      get_status("R3 status write keeps latch");
      put_mem(16'h0000, 1);
      set_status(8'h04);
      put_mem(16'h02FF, 1); put_mem(16'h0300, 1); put_mem(16'h03FF, 1);
      set_status(8'h08);
      put_mem(16'h01FF, 1); put_mem(16'h0200, 1);
      set_status(8'h00);
      get_mem(16'h0000, 1, "R5 all protected");
      get_mem(16'h02FF, 2, "R5 quarter boundary");
      get_mem(16'h03FF, 1, "R5 quarter top");
      get_mem(16'h01FF, 2, "R5 half boundary");

      // R6: page wrap on stores
      put_mem(16'h0180, 1);
      put_mem(16'h017E, 4);
      get_mem(16'h0100, 2, "R6 wrapped bytes");
      get_mem(16'h017E, 3, "R6 page tail and next page");

      // R7: array wrap on reads
      put_mem(16'h03FE, 2);
      put_mem(16'h0000, 2);
      get_mem(16'h03FE, 4, "R7 array wrap");

      // R8: repeated status
      open_t();
      xbyte(8'h05, rx);
      for (int k = 0; k < 3; k++) begin
         xbyte(8'h00, rx);
         check8("R8 status repeat", rx, m_status());
      end
      close_t();

      // R9: aborts
      put_mem(16'h0050, 1);
      open_t();
      xbyte(8'h02, rx);
      bits(16'h0050, 16, r);
      bits(16'h00A5, 5, r);
      close_t();
      get_mem(16'h0050, 1, "R9 partial data byte dropped");
      open_t();
      xbyte(8'h03, rx);
      bits(16'h0010, 16, r);
      bits(16'h0000, 4, r);
      close_t();
      check8("R9 output high after release", {7'd0, ser_out}, 8'h01);
      open_t();
      bits(16'h0000, 5, r);
      close_t();
      get_status("R9 fresh command after partial");

      // R10: pause mid-read
      open_t();
      xbyte(8'h03, rx);
      bits(16'h0050, 16, r);
      pause_n = 1'b0;
      tick(4);
      for (int k = 0; k < 3; k++) begin
         ser_in = 1'b1;
         ser_clk = 1'b1; tick(HALF);
         ser_clk = 1'b0; tick(HALF);
      end
      pause_n = 1'b1;
      tick(4);
      xbyte(8'h00, rx);
      check8("R10 pause ignored clocks", rx, mdl[16'h050]);
      close_t();

      // R11: unsupported command parks
      simple_cmd(8'h04);
      open_t();
      xbyte(8'h9F, rx);
      xbyte(8'h06, rx);
      check8("R11 parked output", rx, 8'hFF);
      close_t();
      get_status("R11 parked ignores later bits");

      // R12: address masking
      simple_cmd(8'h06);
      put_mem(16'h8005, 1);
      get_mem(16'h0005, 1, "R12 masked address");
      get_mem(16'hFC05, 1, "R12 upper bits ignored on read");

      // random mix
      for (int it = 0; it < 40; it++) begin
         logic [15:0] a16;
         int op;
         op = int'($urandom % 6);
         a16 = {6'($urandom), 10'h100 + 10'($urandom % 64)};
         case (op)
            0: simple_cmd(8'h06);
            1: simple_cmd(8'h04);
            2: set_status(8'($urandom));
            3: put_mem(a16, 1 + int'($urandom % 3));
            4: get_mem(a16, 1 + int'($urandom % 3), "R2 random read");
            default: get_status("R3 random status");
         endcase
      end
      set_status(8'h00);
      simple_cmd(8'h06);
      get_mem(16'h0100, 64, "R7 random region sweep");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule